// File: doc/BRIEF.md
# DAC Interface Control Register Bank

This block is the software-visible control and status bank of a DAC interface core. A host reaches it through a word-addressed port: a write strobe with an address and a 32-bit data word, and a read path whose data follows the address in the same cycle. The registered fields drive the datapath directly. They cover the core and clock-manager reset releases, an active-low clock enable that leaves the block inverted, the interface shape (lane count, single or double data rate, parity or frame mode, parity polarity, channel count, sample coding) and an 8-bit rate divisor.

Three access behaviours sit beside the plain read/write fields. A frame register emits a one-cycle pulse and clears itself. Two sticky flags record overflow and underflow events from the datapath, and each is cleared only when software writes 1 to its bit. Any address outside the map reads as zero, and a write to such an address has no effect.

Top module: `dac_cfg_regs`

## Requirements
- R1: After reset every mapped register reads 0, `core_rst_n_o` and `clkmgr_rst_n_o` are 0, and `clk_en_o` is 1.
- R2: A write to word 0x10 sets `core_rst_n_o` from data bit 0 and `clkmgr_rst_n_o` from data bit 1 on the next cycle, and both read back at those positions.
- R3: Bit 2 of word 0x10 is an active-low clock enable: `clk_en_o` is its inverse, and it reads back as written.
- R4: Word 0x12 holds SDR select at bit 16, lane count at bits 12:8, odd parity at bit 7, parity mode at bit 6, single channel at bit 5 and offset binary at bit 4, each driving its output. All other bits, including reserved bits 3:0, read 0 whatever was written.
- R5: Word 0x13 holds an 8-bit rate in bits 7:0 that drives `rate_o`. Upper data bits are dropped and read 0.
- R6: Writing 1 to bit 0 of word 0x14 makes `frame_pulse_o` high for exactly the next cycle. The bit reads 1 during that cycle and 0 after it. Writing 0 produces no pulse.
- R7: In word 0x22, bit 1 (overflow) and bit 0 (underflow) are set by `ovf_evt_i` and `unf_evt_i` respectively, and they stay set after the event ends.
- R8: Writing 1 to a bit of word 0x22 clears only that flag. Writing 0 leaves it unchanged.
- R9: When an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R10: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| ovf_evt_i | input | 1 | Overflow event from the datapath |
| unf_evt_i | input | 1 | Underflow event from the datapath |
| core_rst_n_o | output | 1 | Core reset release |
| clkmgr_rst_n_o | output | 1 | Clock-manager reset release |
| clk_en_o | output | 1 | Clock enable (inverse of stored bit) |
| sdr_mode_o | output | 1 | 1 = SDR, 0 = DDR |
| lane_count_o | output | 5 | Active lane count |
| par_odd_o | output | 1 | 1 = odd parity, 0 = even |
| par_en_o | output | 1 | 1 = parity mode, 0 = frame mode |
| single_chan_o | output | 1 | 1 = one RF channel, 0 = two |
| offset_bin_o | output | 1 | 1 = offset binary, 0 = two's complement |
| rate_o | output | 8 | Rate divisor |
| frame_pulse_o | output | 1 | One-cycle frame pulse |

## Verification
The hardest case to reach is a datapath event and a software clearing write arriving at the same flag on the same clock edge, because the event and the write come from separate parties. The stimulus raises `ovf_evt_i` and, in the same cycle, drives a write of 1 to that flag's bit in word 0x22. It then reads the flag back. Next it repeats the write without the event, to show that the clear still works. A partial clear that writes 1 to only one bit while both flags are set shows that each flag is cleared independently.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_RST   = 8'h10;
  localparam logic [ADDR_W-1:0] A_CFG   = 8'h12;
  localparam logic [ADDR_W-1:0] A_RATE  = 8'h13;
  localparam logic [ADDR_W-1:0] A_FRAME = 8'h14;
  localparam logic [ADDR_W-1:0] A_FLAGS = 8'h22;

  typedef enum int unsigned {
    S_RST   = 0,
    S_CFG   = 1,
    S_RATE  = 2,
    S_FRAME = 3,
    S_FLAGS = 4
  } sel_e;

  localparam int unsigned N_SEL = 5;
endpackage

// File: rtl/dac_cfg_decode.sv
module dac_cfg_decode
  import dac_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_SEL-1:0]  sel_o
);
  always_comb begin
    sel_o = '0;
    case (addr_i)
      A_RST:   sel_o[S_RST]   = 1'b1;
      A_CFG:   sel_o[S_CFG]   = 1'b1;
      A_RATE:  sel_o[S_RATE]  = 1'b1;
      A_FRAME: sel_o[S_FRAME] = 1'b1;
      A_FLAGS: sel_o[S_FLAGS] = 1'b1;
      default: sel_o = '0;
    endcase
  end

  // R10
  always_comb begin
    sel_onehot_chk: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/dac_cfg_pulse.sv
module dac_cfg_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= fire_i;
  end

  // R6
  pulse_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> pulse_o);
  // R6
  pulse_selfclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> !pulse_o);
endmodule

// File: rtl/dac_cfg_sticky.sv
module dac_cfg_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs
  import dac_cfg_pkg::*;
#(
  parameter int unsigned LANE_W  = 5,
  parameter int unsigned RATE_W  = 8,
  parameter int unsigned N_FLAGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ovf_evt_i,
  input  logic              unf_evt_i,
  output logic              core_rst_n_o,
  output logic              clkmgr_rst_n_o,
  output logic              clk_en_o,
  output logic              sdr_mode_o,
  output logic [LANE_W-1:0] lane_count_o,
  output logic              par_odd_o,
  output logic              par_en_o,
  output logic              single_chan_o,
  output logic              offset_bin_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              frame_pulse_o
);
  localparam int unsigned LANE_LSB = 8;
  localparam int unsigned LANE_MSB = LANE_LSB + LANE_W - 1;

  logic [N_SEL-1:0]   sel;
  logic [N_SEL-1:0]   wsel;
  logic               ce_n_q;
  logic [N_FLAGS-1:0] flag_evt;
  logic [N_FLAGS-1:0] flag_q;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata_i[DATA_W-1:17], wdata_i[15:LANE_MSB+1], wdata_i[3:0]};

  dac_cfg_decode u_dec (.addr_i(addr_i), .sel_o(sel));
  assign wsel = wr_en_i ? sel : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_rst_n_o   <= 1'b0;
      clkmgr_rst_n_o <= 1'b0;
      ce_n_q         <= 1'b0;
      sdr_mode_o     <= 1'b0;
      lane_count_o   <= '0;
      par_odd_o      <= 1'b0;
      par_en_o       <= 1'b0;
      single_chan_o  <= 1'b0;
      offset_bin_o   <= 1'b0;
      rate_o         <= '0;
    end else begin
      if (wsel[S_RST]) begin
        core_rst_n_o   <= wdata_i[0];
        clkmgr_rst_n_o <= wdata_i[1];
        ce_n_q         <= wdata_i[2];
      end
      if (wsel[S_CFG]) begin
        sdr_mode_o    <= wdata_i[16];
        lane_count_o  <= wdata_i[LANE_MSB:LANE_LSB];
        par_odd_o     <= wdata_i[7];
        par_en_o      <= wdata_i[6];
        single_chan_o <= wdata_i[5];
        offset_bin_o  <= wdata_i[4];
      end
      if (wsel[S_RATE]) rate_o <= wdata_i[RATE_W-1:0];
    end
  end

  assign clk_en_o = ~ce_n_q;

  dac_cfg_pulse u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wsel[S_FRAME] & wdata_i[0]),
    .pulse_o(frame_pulse_o)
  );

  // bit 1 overflow, bit 0 underflow
  assign flag_evt = {ovf_evt_i, unf_evt_i};

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    dac_cfg_sticky u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (flag_evt[g]),
      .clr_i (wsel[S_FLAGS] & wdata_i[g]),
      .flag_o(flag_q[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel[S_RST]: rdata_o[2:0] = {ce_n_q, clkmgr_rst_n_o, core_rst_n_o};
      sel[S_CFG]: begin
        rdata_o[16]                = sdr_mode_o;
        rdata_o[LANE_MSB:LANE_LSB] = lane_count_o;
        rdata_o[7:4]               = {par_odd_o, par_en_o, single_chan_o, offset_bin_o};
      end
      sel[S_RATE]:  rdata_o[RATE_W-1:0]  = rate_o;
      sel[S_FRAME]: rdata_o[0]           = frame_pulse_o;
      sel[S_FLAGS]: rdata_o[N_FLAGS-1:0] = flag_q;
      default:      rdata_o = '0;
    endcase
  end

  // R2
  rst_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wsel[S_RST] |=> (core_rst_n_o == $past(wdata_i[0])) && (clkmgr_rst_n_o == $past(wdata_i[1])));
  // R3
  ce_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wsel[S_RST] |=> (clk_en_o != $past(wdata_i[2])));
  // R5
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wsel[S_RATE] |=> $stable(rate_o));
  // R4
  always_comb begin
    if (sel[S_CFG]) cfg_reserved_chk: assert (rdata_o[3:0] == 4'b0);
  end
endmodule

// File: tb/dac_cfg_regs_test.sv
module dac_cfg_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ovf_evt = 1'b0, unf_evt = 1'b0;
  logic        core_rst_n, clkmgr_rst_n, clk_en, sdr_mode, par_odd, par_en, single_chan, offset_bin;
  logic [4:0]  lane_count;
  logic [7:0]  rate;
  logic        frame_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_cfg_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ovf_evt_i(ovf_evt), .unf_evt_i(unf_evt),
    .core_rst_n_o(core_rst_n), .clkmgr_rst_n_o(clkmgr_rst_n), .clk_en_o(clk_en),
    .sdr_mode_o(sdr_mode), .lane_count_o(lane_count), .par_odd_o(par_odd),
    .par_en_o(par_en), .single_chan_o(single_chan), .offset_bin_o(offset_bin),
    .rate_o(rate), .frame_pulse_o(frame_pulse)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write at a falling edge, captured at the following rising edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  // {addr, write data, expected readback}
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {8'h10, 32'h0000_0007, 32'h0000_0007},  // R2 R3
    {8'h12, 32'hFFFF_FFFF, 32'h0001_1FF0},  // R4 reserved dropped
    {8'h12, 32'h0000_0450, 32'h0000_0450},  // R4 4 lanes
    {8'h12, 32'h0001_0120, 32'h0001_0120},  // R4 SDR, 1 lane, single chan
    {8'h13, 32'hABCD_1234, 32'h0000_0034},  // R5
    {8'h13, 32'h0000_00FF, 32'h0000_00FF},  // R5
    {8'h55, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    {8'h10, 32'h0000_0001, 32'h0000_0001}   // R2
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset defaults
    rd_check("R1", 8'h10, 0);
    rd_check("R1", 8'h12, 0);
    rd_check("R1", 8'h13, 0);
    rd_check("R1", 8'h14, 0);
    rd_check("R1", 8'h22, 0);
    check("R1", {core_rst_n, clkmgr_rst_n, clk_en}, 3'b001);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd_check("R2-table", VEC[i][71:64], VEC[i][31:0]);
    end
    // state after table: rst reg = 1, cfg = 0x10120, rate = 0xFF
    check("R2", {core_rst_n, clkmgr_rst_n}, 2'b10);
    check("R4", {sdr_mode, lane_count, par_odd, par_en, single_chan, offset_bin}, {1'b1, 5'd1, 4'b0010});
    check("R5", rate, 8'hFF);
    // R10 unmapped write left mapped regs unchanged
    rd_check("R10", 8'h22, 0);

    // R3 clock enable inversion
    wr(8'h10, 32'h4);
    check("R3", clk_en, 1'b0);
    wr(8'h10, 32'h3);
    check("R3", clk_en, 1'b1);
    check("R2", {core_rst_n, clkmgr_rst_n}, 2'b11);

    // R4 parity fields
    wr(8'h12, 32'h0000_02C0);
    check("R4", {lane_count, par_odd, par_en, single_chan, offset_bin}, {5'd2, 4'b1100});

    // R6 frame pulse
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h14; wdata = 32'h1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6", frame_pulse, 1'b1);
    rd_check("R6", 8'h14, 1);
    @(negedge clk);
    check("R6", frame_pulse, 1'b0);
    rd_check("R6", 8'h14, 0);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h14; wdata = 32'h0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6", frame_pulse, 1'b0);

    // R7 sticky capture
    @(negedge clk); ovf_evt = 1'b1;
    @(negedge clk); ovf_evt = 1'b0;
    repeat (2) @(negedge clk);
    rd_check("R7", 8'h22, 32'h2);
    @(negedge clk); unf_evt = 1'b1;
    @(negedge clk); unf_evt = 1'b0;
    rd_check("R7", 8'h22, 32'h3);

    // R8 per-bit clear, zero write no effect
    wr(8'h22, 32'h0);
    rd_check("R8", 8'h22, 32'h3);
    wr(8'h22, 32'h1);
    rd_check("R8", 8'h22, 32'h2);

    // R9 set wins over clear in the same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h22; wdata = 32'h2; ovf_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ovf_evt = 1'b0;
    rd_check("R9", 8'h22, 32'h2);
    wr(8'h22, 32'h2);
    rd_check("R8", 8'h22, 32'h0);

    // R1 asynchronous reset returns defaults
    @(negedge clk); rst_n = 1'b0;
    #1;
    rd_check("R1", 8'h10, 0);
    rd_check("R1", 8'h13, 0);
    check("R1", clk_en, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule